// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external asynchronous static RAM of 128K bytes. The host asks for one access at a time through a valid/ready handshake that carries a 17-bit address, a write flag and a write byte. A read returns its byte together with a one-cycle valid pulse. On the memory side the controller drives a select pair of opposite polarity, an output-enable strobe, a write-enable strobe and a split data bus (data out, data in and a drive enable).

Each strobe phase lasts a whole number of clock cycles. That number comes from the memory's minimum timing figures and the clock period parameter `CLK_NS`. Each time is divided by the period and rounded up, and no phase is shorter than one cycle. With the default 10 ns clock, a read holds its strobes for 9 cycles. The memory is then deselected for one cycle and given two more turnaround cycles so that its outputs can float. A write takes one setup cycle, a 6-cycle write pulse and 2 recovery cycles. The controller drives the data bus only during the pulse and the first recovery cycle.

Top module: `sram_async_ctl`

## Requirements
- R1: Out of reset and whenever idle: `req_ready` is 1, `mem_cs_n` is 1, `mem_cs` is 0, `mem_oe_n` is 1, `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R2: A request is taken only on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from that edge until the access and its turnaround have ended. A request presented while `req_ready` is 0 starts no access and leaves memory contents unchanged.
- R3: A read holds `mem_cs_n`=0, `mem_cs`=1, `mem_oe_n`=0 and `mem_we_n`=1 for 9 cycles with the defaults. This count is the largest rounded-up value of the read cycle, address access, select access and output-enable access times. The data is sampled on the last edge of that window. `rsp_valid` is then high for exactly one cycle, with that byte on `rsp_rdata`.
- R4: After a read, the memory is deselected for one cycle plus 2 turnaround cycles. `req_ready` returns to 1 after the 12th rising edge that follows the accepting edge.
- R5: A write has three parts. First, one setup cycle with both selects active and `mem_we_n`=1. Then `mem_we_n`=0 for 6 cycles. Then 2 recovery cycles with selects still active and `mem_we_n`=1. `req_ready` returns to 1 after the 9th rising edge that follows the accepting edge.
- R6: `mem_oe_n` stays 1 for the whole of a write. `mem_oe_n` and `mem_we_n` are never 0 together.
- R7: `mem_dq_oe` is 1 for exactly 7 cycles per write: the 6 pulse cycles and the first recovery cycle. During that time `mem_dq_o` carries the write byte, which the memory holds when `mem_we_n` rises. `mem_dq_oe` is never 1 while `mem_oe_n` is 0, and it is 0 for reads.
- R8: `mem_addr` stays constant while `mem_cs_n` is 0.
- R9: `rsp_valid` pulses exactly once per read and never during or after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` ns |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | 17 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse, read data valid |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address pins |
| mem_cs_n | output | 1 | Active-low select |
| mem_cs | output | 1 | Active-high select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_o | output | 8 | Data driven toward memory |
| mem_dq_i | input | 8 | Data returned from memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The assertions check the following on every cycle:
- the memory is deselected and the bus is released while the controller is idle;
- ready drops after an accepted request;
- output enable and write enable are never asserted together;
- the bus is never driven while the memory may be driving it;
- the address stays still under an active select;
- a response pulse lasts one cycle and follows a read strobe.

Some behaviour only the bench scenarios can show:
- the exact length of each strobe phase;
- the response latency;
- that each written byte reaches the memory model and reads back correctly, including the highest and lowest addresses;
- that a request held asserted while the controller is busy neither starts a second access nor corrupts memory.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_RD_ACCESS  = 3'd1,
    ST_RD_DONE    = 3'd2,
    ST_WR_SETUP   = 3'd3,
    ST_WR_STROBE  = 3'd4,
    ST_WR_RECOVER = 3'd5,
    ST_TURNAROUND = 3'd6
  } sramc_state_e;

  // Minimum time in ns -> whole cycles, rounded up, never below one.
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // a - b, but at least one cycle.
  function automatic int unsigned sub_floor1(input int unsigned a, input int unsigned b);
    return (a > b + 1) ? (a - b) : 1;
  endfunction

endpackage

// File: rtl/sramc_phase_timer.sv
module sramc_phase_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= load_val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/sramc_fsm.sv
module sramc_fsm
  import sramc_pkg::*;
#(
  parameter int unsigned N_RD  = 9,
  parameter int unsigned N_WSU = 1,
  parameter int unsigned N_WP  = 6,
  parameter int unsigned N_WRC = 2,
  parameter int unsigned N_TA  = 2,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             expire,
  output sramc_state_e     state,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             rd_sample,
  output logic             drive_en
);
  localparam logic [CNT_W-1:0] L_RD  = CNT_W'(N_RD - 1);
  localparam logic [CNT_W-1:0] L_WSU = CNT_W'(N_WSU - 1);
  localparam logic [CNT_W-1:0] L_WP  = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] L_WRC = CNT_W'(N_WRC - 1);
  localparam logic [CNT_W-1:0] L_TA  = CNT_W'(N_TA - 1);

  sramc_state_e state_q, state_n;
  logic         drive_q;

  always_comb begin
    state_n  = state_q;
    load     = 1'b0;
    load_val = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        state_n  = req_write ? ST_WR_SETUP : ST_RD_ACCESS;
        load     = 1'b1;
        load_val = req_write ? L_WSU : L_RD;
      end
      ST_RD_ACCESS: if (expire) begin
        state_n = ST_RD_DONE;
        load    = 1'b1;
      end
      ST_RD_DONE: if (expire) begin
        state_n  = ST_TURNAROUND;
        load     = 1'b1;
        load_val = L_TA;
      end
      ST_WR_SETUP: if (expire) begin
        state_n  = ST_WR_STROBE;
        load     = 1'b1;
        load_val = L_WP;
      end
      ST_WR_STROBE: if (expire) begin
        state_n  = ST_WR_RECOVER;
        load     = 1'b1;
        load_val = L_WRC;
      end
      ST_WR_RECOVER: if (expire) state_n = ST_IDLE;
      ST_TURNAROUND: if (expire) state_n = ST_IDLE;
      default:       state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      drive_q <= 1'b0;
    end else begin
      state_q <= state_n;
      // bus driven over the write pulse and one cycle after it ends
      drive_q <= (state_n == ST_WR_STROBE) ||
                 ((state_q == ST_WR_STROBE) && (state_n == ST_WR_RECOVER));
    end
  end

  assign state     = state_q;
  assign accept    = (state_q == ST_IDLE) && req_valid;
  assign rd_sample = (state_q == ST_RD_ACCESS) && expire;
  assign drive_en  = drive_q;
endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sramc_state_e      state,
  input  logic              accept,
  input  logic              rd_sample,
  input  logic              drive_en,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              valid_q;
  logic              sel_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (rd_sample) rdata_q <= mem_dq_i;
      valid_q <= rd_sample;
    end
  end

  assign sel_active = (state == ST_RD_ACCESS) || (state == ST_WR_SETUP) ||
                      (state == ST_WR_STROBE) || (state == ST_WR_RECOVER);

  assign mem_addr  = addr_q;
  assign mem_cs_n  = ~sel_active;
  assign mem_cs    = sel_active;
  assign mem_oe_n  = (state != ST_RD_ACCESS);
  assign mem_we_n  = (state != ST_WR_STROBE);
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = drive_en;
  assign rsp_valid = valid_q;
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned T_RC_NS    = 85,
  parameter int unsigned T_ACC_NS   = 85,
  parameter int unsigned T_CSACC_NS = 85,
  parameter int unsigned T_OEACC_NS = 40,
  parameter int unsigned T_WC_NS    = 85,
  parameter int unsigned T_WP_NS    = 60,
  parameter int unsigned T_CW_NS    = 70,
  parameter int unsigned T_AW_NS    = 70,
  parameter int unsigned T_AS_NS    = 0,
  parameter int unsigned T_WR_NS    = 0,
  parameter int unsigned T_DW_NS    = 35,
  parameter int unsigned T_HZ_NS    = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);
  // Phase lengths in cycles.
  localparam int unsigned N_RD = max2(max2(ns_to_cyc(T_RC_NS, CLK_NS), ns_to_cyc(T_ACC_NS, CLK_NS)),
                                      max2(ns_to_cyc(T_CSACC_NS, CLK_NS), ns_to_cyc(T_OEACC_NS, CLK_NS)));
  localparam int unsigned N_WSU = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int unsigned N_WP  = max2(max2(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_DW_NS, CLK_NS)),
                                       max2(sub_floor1(ns_to_cyc(T_CW_NS, CLK_NS), N_WSU),
                                            sub_floor1(ns_to_cyc(T_AW_NS, CLK_NS), N_WSU)));
  localparam int unsigned N_WRC = max2(ns_to_cyc(T_WR_NS, CLK_NS),
                                       sub_floor1(ns_to_cyc(T_WC_NS, CLK_NS), N_WSU + N_WP));
  // one deselected cycle precedes the turnaround
  localparam int unsigned N_TA  = sub_floor1(ns_to_cyc(T_HZ_NS, CLK_NS), 1);
  localparam int unsigned N_MAX = max2(max2(N_RD, N_WP), max2(max2(N_WSU, N_WRC), N_TA));
  localparam int unsigned CNT_W = $clog2(N_MAX + 1);

  sramc_state_e     state;
  logic             phase_load, phase_expire;
  logic [CNT_W-1:0] phase_len;
  logic             req_accept, rd_sample, drive_en;

  sramc_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(phase_load), .load_val(phase_len), .expire(phase_expire)
  );

  sramc_fsm #(
    .N_RD(N_RD), .N_WSU(N_WSU), .N_WP(N_WP), .N_WRC(N_WRC), .N_TA(N_TA), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .expire(phase_expire), .state(state), .load(phase_load), .load_val(phase_len),
    .accept(req_accept), .rd_sample(rd_sample), .drive_en(drive_en)
  );

  sramc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .state(state), .accept(req_accept), .rd_sample(rd_sample),
    .drive_en(drive_en), .req_addr(req_addr), .req_wdata(req_wdata), .mem_dq_i(mem_dq_i),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
endmodule

// File: rtl/sramc_checker.sv
module sramc_checker #(
  parameter int unsigned ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_cs_n,
  input logic              mem_cs,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              mem_dq_oe
);
  assert_idle_deselect_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_ready_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_valid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_strobe_selected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_cs_n && mem_cs));

  assert_no_oe_we_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_bus_no_fight_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

  assert_valid_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));
endmodule

bind sram_async_ctl sramc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_cs(mem_cs),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_async_ctl_tb.sv
module sram_async_ctl_tb;
  // Expected phase lengths at a 10 ns clock, restated from the requirements.
  localparam int EXP_RD_STROBE = (85 + 9) / 10;   // R3: 9
  localparam int EXP_RD_LAT    = EXP_RD_STROBE + 1 + 2; // R4: 12
  localparam int EXP_WE_LOW    = 6;               // R5
  localparam int EXP_WR_LAT    = 1 + 6 + 2;       // R5: 9
  localparam int EXP_DRIVE     = 7;               // R7

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, req_ready, req_write, rsp_valid;
  logic [16:0] req_addr, mem_addr;
  logic [7:0]  req_wdata, rsp_rdata, mem_dq_o, mem_dq_i;
  logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe;

  sram_async_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Memory model and the bench's own expectation of its contents.
  logic [7:0] model_mem  [logic [16:0]];
  logic [7:0] shadow_mem [logic [16:0]];
  int         wr_strobes;
  bit         wr_drive_ok;

  always @(negedge clk) begin
    if (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n)
      mem_dq_i <= model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'h00;
    else
      mem_dq_i <= 8'hA5;
  end

  always @(posedge mem_we_n) begin
    if (rst_n === 1'b1 && mem_cs_n === 1'b0 && mem_cs === 1'b1) begin
      model_mem[mem_addr] = mem_dq_o;
      wr_strobes++;
      if (mem_dq_oe !== 1'b1) wr_drive_ok = 1'b0;
    end
  end

  // Per-operation monitor, sampled 2 ns after each rising edge.
  int         oe_lo, we_lo, drv_cnt, val_cnt, viol;
  logic [7:0] last_rdata;
  logic [16:0] prev_addr;
  bit          prev_sel;

  always @(posedge clk) begin
    #2;
    if (!mem_oe_n) oe_lo++;
    if (!mem_we_n) we_lo++;
    if (mem_dq_oe) drv_cnt++;
    if (rsp_valid) begin val_cnt++; last_rdata = rsp_rdata; end
    if (mem_dq_oe && !mem_oe_n) viol++;
    if (!mem_oe_n && !mem_we_n) viol++;
    if ((mem_cs_n == 1'b0) != (mem_cs == 1'b1)) viol++;
    if (prev_sel && !mem_cs_n && mem_addr != prev_addr) viol++;
    prev_sel  = !mem_cs_n;
    prev_addr = mem_addr;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk({tag, " ready"}, req_ready, 1);
    chk({tag, " pins {cs_n,cs,oe_n,we_n,dq_oe}"},
        {mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
  endtask

  // One access. flood=1 keeps a conflicting write request asserted while busy.
  task automatic run_op(input bit wr, input logic [16:0] a, input logic [7:0] d, input bit flood);
    int lat;
    @(negedge clk);
    oe_lo = 0; we_lo = 0; drv_cnt = 0; val_cnt = 0; viol = 0;
    wr_strobes = 0; wr_drive_ok = 1'b1;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    #1;
    if (flood) begin
      req_write = 1'b1; req_addr = a + 17'd1; req_wdata = ~d;
    end else begin
      req_valid = 1'b0;
    end
    lat = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (req_ready) break;
      lat++;
    end
    req_valid = 1'b0;
    if (wr) begin
      shadow_mem[a] = d;
      chk("R5 write latency", lat, EXP_WR_LAT);
      chk("R5 we_n low cycles", we_lo, EXP_WE_LOW);
      chk("R6 oe_n low during write", oe_lo, 0);
      chk("R7 drive cycles", drv_cnt, EXP_DRIVE);
      chk("R7 data driven at we_n rise", {31'd0, wr_drive_ok}, 1);
      chk("R2 one write strobe per accepted write", wr_strobes, 1);
      chk("R9 no rsp_valid on write", val_cnt, 0);
    end else begin
      chk("R4 read latency", lat, EXP_RD_LAT);
      chk("R3 oe_n low cycles", oe_lo, EXP_RD_STROBE);
      chk("R7 no drive on read", drv_cnt, 0);
      chk("R9 one rsp_valid per read", val_cnt, 1);
      chk("R3 read data", last_rdata,
          shadow_mem.exists(a) ? shadow_mem[a] : 8'h00);
    end
    chk("R8 R6 R7 cycle rule violations", viol, 0);
    check_idle("R1 after op");
  endtask

  // {write, addr[16:0], data[7:0]}
  localparam int NV = 9;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 17'h00000, 8'h3C},
    {1'b1, 17'h1FFFF, 8'hC3},
    {1'b1, 17'h0AAAA, 8'h55},
    {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h1FFFF, 8'h00},
    {1'b1, 17'h00000, 8'hFF},
    {1'b0, 17'h00000, 8'h00},
    {1'b0, 17'h0AAAA, 8'h00},
    {1'b0, 17'h12345, 8'h00}
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check_idle("R1 in reset");
    chk("R9 rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1 after reset");

    // R2: request with valid low for several cycles starts nothing
    req_addr = 17'h00123; req_write = 1'b1; req_wdata = 8'h99;
    repeat (4) @(negedge clk);
    chk("R2 no access without valid", {31'd0, mem_cs_n}, 1);

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][25], VEC[v][24:8], VEC[v][7:0], 1'b0);

    // R2: request held while busy is ignored; next write lands only at its own address
    run_op(1'b1, 17'h00100, 8'h5A, 1'b1);
    run_op(1'b0, 17'h00101, 8'h00, 1'b0);
    run_op(1'b0, 17'h00100, 8'h00, 1'b0);
    chk("R2 busy request left memory untouched", model_mem.exists(17'h00101) ? 1 : 0, 0);

    // back-to-back read then write then read at the top address
    run_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);
    run_op(1'b1, 17'h1FFFF, 8'h0F, 1'b0);
    run_op(1'b0, 17'h1FFFF, 8'h00, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule